// File: doc/BRIEF.md
# Constant Stride Stream Detector

This block observes a sequence of memory reference addresses, one per cycle when `ref_valid` is high. It recognises streams, meaning runs of references in which each address is the one before it plus a fixed, non-zero stride. Strides are signed, so both ascending and descending runs qualify. A stream is first recognised when a new reference, together with two earlier references still held in a bounded history window, forms three equally spaced addresses. The stream is then placed in a small table of active streams. After that, every reference that lands exactly one stride past the stream's last address is matched against the table.

For each accepted reference the block reports, one cycle later, whether the reference belongs to a stream, whether it has just confirmed a new stream, which table slot holds the stream and how long the stream is. It also keeps three running counters: all references, references covered by a stream (gross), and covered references that a prefetcher could have used (net). The net count leaves out the three references spent confirming each stream. Together the counters give the gross and net cover rates.

Top module: `stride_stream_detector`

## Requirements
- R1: After reset all outputs are zero, the stream table holds no valid entries and the history window is empty.
- R2: A valid reference whose address equals `last + stride` of a valid table entry is a table hit. The response, visible after the clock edge that samples the reference, shows `hit_stream`=1, `hit_new`=0, `hit_id` set to the entry index, and `hit_len` set to the entry's incremented length. The entry's last address becomes the reference address. If several entries match, the lowest index wins.
- R3: A valid reference that is not a table hit confirms a new stream when two earlier window references W_near (newer) and W_far (older) satisfy addr − W_near = W_near − W_far ≠ 0. The new entry stores addr and that stride with length 3, and the response shows `hit_stream`=1, `hit_new`=1 and `hit_len`=3.
- R4: The window holds the WIN_DEPTH most recent valid references, stream hits included. A reference WIN_DEPTH+1 or more references back can no longer take part in a confirmation.
- R5: Repeated identical addresses (stride zero) never form a stream.
- R6: Descending streams (negative stride, taken modulo 2^ADDR_W) are confirmed and followed in the same way as ascending ones.
- R7: A new stream takes the lowest-index invalid entry. When all entries are valid it replaces the least recently used one. Both a table hit and an allocation count as a use.
- R8: `cnt_total` grows by 1 per valid reference. `cnt_gross` grows by 1 per table hit and by 3 per confirmation. `cnt_net` grows by 1 per table hit only.
- R9: An entry's length saturates at 2^LEN_W − 1. The entry still hits after its length saturates.
- R10: In a cycle with `ref_valid`=0 the next response has `hit_valid`, `hit_stream` and `hit_new` low, and neither the counters nor the table change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_addr | input | ADDR_W | Reference address |
| hit_valid | output | 1 | Response belongs to a reference sampled at the previous edge |
| hit_stream | output | 1 | Reference belongs to a stream |
| hit_new | output | 1 | Reference confirmed a new stream |
| hit_id | output | $clog2(TBL_ENTRIES) | Table slot of the stream |
| hit_len | output | LEN_W | Stream length after this reference |
| cnt_total | output | CNT_W | References seen |
| cnt_gross | output | CNT_W | References covered by a stream |
| cnt_net | output | CNT_W | Covered references excluding confirmation references |

## Verification
The bench builds the block with ADDR_W=48, LEN_W=4, and the default window of 32 and table of 8. The wide address lets filler references sit at distinct single-bit addresses. No address of that kind lies midway between two others, so the fillers can walk a reference to exactly the window edge without creating stray streams. The 4-bit length makes saturation reachable within 20 references, and the default table size lets nine interleaved streams force an eviction whose victim shows the recency order.

// File: rtl/sd_pkg.sv
package sd_pkg;

    typedef enum logic [1:0] {
        SD_KIND_NONE = 2'd0,
        SD_KIND_HIT  = 2'd1,
        SD_KIND_NEW  = 2'd2
    } sd_kind_e;

endpackage

// File: rtl/sd_window.sv
module sd_window #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    output logic [DEPTH-1:0][ADDR_W-1:0]  win_addr,
    output logic [DEPTH-1:0]              win_vld
);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0]             vld;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (push) begin
            w_d.addr[0] = push_addr;
            w_d.vld[0]  = 1'b1;
            for (int i = 1; i < DEPTH; i++) begin
                w_d.addr[i] = w_q.addr[i-1];
                w_d.vld[i]  = w_q.vld[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign win_addr = w_q.addr;
    assign win_vld  = w_q.vld;

endmodule

// File: rtl/sd_pair_search.sv
module sd_pair_search #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic [ADDR_W-1:0]             new_addr,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  win_addr,
    input  logic [DEPTH-1:0]              win_vld,
    output logic                          found,
    output logic [ADDR_W-1:0]             stride
);

    logic [ADDR_W-1:0] cand;

    // Newest middle reference first; any older partner at equal spacing.
    always_comb begin
        found  = 1'b0;
        stride = '0;
        cand   = '0;
        for (int k = 0; k < DEPTH - 1; k++) begin
            cand = new_addr - win_addr[k];
            if (!found && win_vld[k] && (cand != '0)) begin
                for (int m = k + 1; m < DEPTH; m++) begin
                    if (!found && win_vld[m] &&
                        ((win_addr[k] - win_addr[m]) == cand)) begin
                        found  = 1'b1;
                        stride = cand;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sd_entry_match.sv
module sd_entry_match #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0]               new_addr,
    input  logic [ENTRIES-1:0]              ent_vld,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]  ent_last,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]  ent_stride,
    output logic                            hit,
    output logic [IDX_W-1:0]                hit_idx
);

    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = ent_vld[g] && (new_addr == (ent_last[g] + ent_stride[g]));
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/sd_lru.sv
module sd_lru #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ENTRIES-1:0]  ent_vld,
    input  logic                touch,
    input  logic [IDX_W-1:0]    touch_idx,
    output logic [IDX_W-1:0]    victim
);

    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] age;
    } lru_t;

    lru_t l_d, l_q;
    logic have_free;

    always_comb begin
        have_free = 1'b0;
        victim    = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                have_free = 1'b1;
                victim    = IDX_W'(i);
            end
        end
        if (!have_free) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (l_q.age[i] == IDX_W'(ENTRIES - 1)) begin
                    victim = IDX_W'(i);
                end
            end
        end
    end

    always_comb begin
        l_d = l_q;
        if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    l_d.age[i] = '0;
                end else if (l_q.age[i] < l_q.age[touch_idx]) begin
                    l_d.age[i] = l_q.age[i] + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                l_q.age[i] <= IDX_W'(i);
            end
        end else begin
            l_q <= l_d;
        end
    end

endmodule

// File: rtl/stride_stream_detector.sv
module stride_stream_detector #(
    parameter int ADDR_W      = 32,
    parameter int WIN_DEPTH   = 32,
    parameter int TBL_ENTRIES = 8,
    parameter int LEN_W       = 8,
    parameter int CNT_W       = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ref_valid,
    input  logic [ADDR_W-1:0]               ref_addr,
    output logic                            hit_valid,
    output logic                            hit_stream,
    output logic                            hit_new,
    output logic [$clog2(TBL_ENTRIES)-1:0]  hit_id,
    output logic [LEN_W-1:0]                hit_len,
    output logic [CNT_W-1:0]                cnt_total,
    output logic [CNT_W-1:0]                cnt_gross,
    output logic [CNT_W-1:0]                cnt_net
);

    import sd_pkg::*;

    localparam int IDX_W       = $clog2(TBL_ENTRIES);
    localparam int CONFIRM_LEN = 3;

    typedef struct packed {
        logic [TBL_ENTRIES-1:0]             vld;
        logic [TBL_ENTRIES-1:0][ADDR_W-1:0] last;
        logic [TBL_ENTRIES-1:0][ADDR_W-1:0] stride;
        logic [TBL_ENTRIES-1:0][LEN_W-1:0]  len;
        logic                               o_valid;
        logic                               o_stream;
        logic                               o_new;
        logic [IDX_W-1:0]                   o_id;
        logic [LEN_W-1:0]                   o_len;
        logic [CNT_W-1:0]                   total;
        logic [CNT_W-1:0]                   gross;
        logic [CNT_W-1:0]                   net;
    } state_t;

    state_t s_d, s_q;

    logic [WIN_DEPTH-1:0][ADDR_W-1:0] win_addr;
    logic [WIN_DEPTH-1:0]             win_vld;
    logic                             pair_found;
    logic [ADDR_W-1:0]                pair_stride;
    logic                             tbl_hit;
    logic [IDX_W-1:0]                 tbl_idx;
    logic [IDX_W-1:0]                 victim;
    logic                             touch;
    logic [IDX_W-1:0]                 touch_idx;
    sd_kind_e                         kind;
    logic [LEN_W-1:0]                 next_len;

    sd_window #(
        .ADDR_W (ADDR_W),
        .DEPTH  (WIN_DEPTH)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ref_valid),
        .push_addr (ref_addr),
        .win_addr  (win_addr),
        .win_vld   (win_vld)
    );

    sd_pair_search #(
        .ADDR_W (ADDR_W),
        .DEPTH  (WIN_DEPTH)
    ) u_pair (
        .new_addr (ref_addr),
        .win_addr (win_addr),
        .win_vld  (win_vld),
        .found    (pair_found),
        .stride   (pair_stride)
    );

    sd_entry_match #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (TBL_ENTRIES),
        .IDX_W   (IDX_W)
    ) u_match (
        .new_addr   (ref_addr),
        .ent_vld    (s_q.vld),
        .ent_last   (s_q.last),
        .ent_stride (s_q.stride),
        .hit        (tbl_hit),
        .hit_idx    (tbl_idx)
    );

    sd_lru #(
        .ENTRIES (TBL_ENTRIES),
        .IDX_W   (IDX_W)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_vld   (s_q.vld),
        .touch     (touch),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    // Classify the incoming reference: table hit wins over fresh detection.
    always_comb begin
        if (!ref_valid) begin
            kind = SD_KIND_NONE;
        end else if (tbl_hit) begin
            kind = SD_KIND_HIT;
        end else if (pair_found) begin
            kind = SD_KIND_NEW;
        end else begin
            kind = SD_KIND_NONE;
        end
    end

    always_comb begin
        next_len = s_q.len[tbl_idx];
        if (next_len != '1) begin
            next_len = next_len + LEN_W'(1);
        end
    end

    always_comb begin
        s_d          = s_q;
        s_d.o_valid  = ref_valid;
        s_d.o_stream = 1'b0;
        s_d.o_new    = 1'b0;
        s_d.o_id     = '0;
        s_d.o_len    = '0;
        touch        = 1'b0;
        touch_idx    = '0;

        if (ref_valid) begin
            s_d.total = s_q.total + CNT_W'(1);
        end

        case (kind)
            SD_KIND_HIT: begin
                s_d.last[tbl_idx] = ref_addr;
                s_d.len[tbl_idx]  = next_len;
                s_d.o_stream      = 1'b1;
                s_d.o_id          = tbl_idx;
                s_d.o_len         = next_len;
                s_d.gross         = s_q.gross + CNT_W'(1);
                s_d.net           = s_q.net + CNT_W'(1);
                touch             = 1'b1;
                touch_idx         = tbl_idx;
            end
            SD_KIND_NEW: begin
                s_d.vld[victim]    = 1'b1;
                s_d.last[victim]   = ref_addr;
                s_d.stride[victim] = pair_stride;
                s_d.len[victim]    = LEN_W'(CONFIRM_LEN);
                s_d.o_stream       = 1'b1;
                s_d.o_new          = 1'b1;
                s_d.o_id           = victim;
                s_d.o_len          = LEN_W'(CONFIRM_LEN);
                s_d.gross          = s_q.gross + CNT_W'(CONFIRM_LEN);
                touch              = 1'b1;
                touch_idx          = victim;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit_valid  = s_q.o_valid;
    assign hit_stream = s_q.o_stream;
    assign hit_new    = s_q.o_new;
    assign hit_id     = s_q.o_id;
    assign hit_len    = s_q.o_len;
    assign cnt_total  = s_q.total;
    assign cnt_gross  = s_q.gross;
    assign cnt_net    = s_q.net;

endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
    parameter int LEN_W = 8,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_valid,
    input logic             hit_valid,
    input logic             hit_stream,
    input logic             hit_new,
    input logic [LEN_W-1:0] hit_len,
    input logic [CNT_W-1:0] cnt_total,
    input logic [CNT_W-1:0] cnt_gross,
    input logic [CNT_W-1:0] cnt_net
);

    logic started_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
        end else begin
            started_q <= 1'b1;
        end
    end

    assert_valid_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (hit_valid == $past(ref_valid)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |-> (!hit_stream && !hit_new));

    assert_new_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_new |-> (hit_stream && (hit_len == LEN_W'(3))));

    assert_hit_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_stream && !hit_new) |-> (hit_len > LEN_W'(3)));

    assert_total_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (cnt_total == $past(cnt_total) + CNT_W'($past(ref_valid))));

    assert_net_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> ((cnt_net - $past(cnt_net)) <= CNT_W'(1)));

    assert_gross_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> ((cnt_gross - $past(cnt_gross)) == CNT_W'(0) ||
                       (cnt_gross - $past(cnt_gross)) == CNT_W'(1) ||
                       (cnt_gross - $past(cnt_gross)) == CNT_W'(3)));

    assert_net_le_gross_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_net <= cnt_gross);

endmodule

bind stride_stream_detector sd_checker #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
) u_sd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_valid  (ref_valid),
    .hit_valid  (hit_valid),
    .hit_stream (hit_stream),
    .hit_new    (hit_new),
    .hit_len    (hit_len),
    .cnt_total  (cnt_total),
    .cnt_gross  (cnt_gross),
    .cnt_net    (cnt_net)
);

// File: tb/tb_stride_stream_detector.sv
module tb_stride_stream_detector;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 48;
    localparam int WIN_DEPTH  = 32;
    localparam int TBL        = 8;
    localparam int LEN_W      = 4;
    localparam int CNT_W      = 32;
    localparam int IDX_W      = $clog2(TBL);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_valid = 1'b0;
    logic [ADDR_W-1:0] ref_addr = '0;
    logic              hit_valid, hit_stream, hit_new;
    logic [IDX_W-1:0]  hit_id;
    logic [LEN_W-1:0]  hit_len;
    logic [CNT_W-1:0]  cnt_total, cnt_gross, cnt_net;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stride_stream_detector #(
        .ADDR_W      (ADDR_W),
        .WIN_DEPTH   (WIN_DEPTH),
        .TBL_ENTRIES (TBL),
        .LEN_W       (LEN_W),
        .CNT_W       (CNT_W)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_valid  (ref_valid),
        .ref_addr   (ref_addr),
        .hit_valid  (hit_valid),
        .hit_stream (hit_stream),
        .hit_new    (hit_new),
        .hit_id     (hit_id),
        .hit_len    (hit_len),
        .cnt_total  (cnt_total),
        .cnt_gross  (cnt_gross),
        .cnt_net    (cnt_net)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Presents one reference at a falling edge; response is read one falling edge later.
    task automatic send(input logic [ADDR_W-1:0] a);
        ref_valid = 1'b1;
        ref_addr  = a;
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic expect_ref(input string tag, input bit s, input bit n,
                              input int id, input int len);
        check({tag, " hit_valid"}, hit_valid, 1);
        check({tag, " hit_stream"}, hit_stream, s);
        check({tag, " hit_new"}, hit_new, n);
        if (s) begin
            check({tag, " hit_id"}, hit_id, id);
            check({tag, " hit_len"}, hit_len, len);
        end
    endtask

    task automatic expect_cnt(input string tag, input int t, input int g, input int n);
        check({tag, " cnt_total"}, cnt_total, t);
        check({tag, " cnt_gross"}, cnt_gross, g);
        check({tag, " cnt_net"}, cnt_net, n);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 hit_valid", hit_valid, 0);
        check("R1 hit_stream", hit_stream, 0);
        expect_cnt("R1", 0, 0, 0);
    endtask

    task automatic t_ascend();
        do_reset();
        send(48'h1000); expect_ref("R3 first", 0, 0, 0, 0);
        send(48'h1040); expect_ref("R3 second", 0, 0, 0, 0);
        send(48'h1080); expect_ref("R3 confirm", 1, 1, 0, 3);
        expect_cnt("R8 after confirm", 3, 3, 0);
        send(48'h10C0); expect_ref("R2 follow", 1, 0, 0, 4);
        expect_cnt("R8 after hit", 4, 4, 1);
    endtask

    task automatic t_descend();
        do_reset();
        send(48'h9000);
        send(48'h8FF8);
        send(48'h8FF0); expect_ref("R6 confirm", 1, 1, 0, 3);
        send(48'h8FE8); expect_ref("R6 follow", 1, 0, 0, 4);
    endtask

    task automatic t_zero();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            send(48'h5000);
            expect_ref("R5 repeat", 0, 0, 0, 0);
        end
        expect_cnt("R5", 4, 0, 0);
    endtask

    task automatic t_idle();
        do_reset();
        send(48'h100); send(48'h110); send(48'h120);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 hit_valid", hit_valid, 0);
            check("R10 hit_stream", hit_stream, 0);
            expect_cnt("R10", 3, 3, 0);
        end
        send(48'h130); expect_ref("R10 state kept", 1, 0, 0, 4);
    endtask

    task automatic t_window(input int fillers, input bit expect_new);
        do_reset();
        send(48'h10);
        send(48'h14);
        for (int i = 0; i < fillers; i++) begin
            send(48'h1 << (8 + i));
            check("R4 filler", hit_stream, 0);
        end
        send(48'h18);
        expect_ref("R4 window edge", expect_new, expect_new, 0, 3);
    endtask

    task automatic t_priority();
        do_reset();
        send(48'h100); send(48'h200); send(48'h300);
        expect_ref("R2 stream A", 1, 1, 0, 3);
        send(48'h370); send(48'h3A0); send(48'h3D0);
        expect_ref("R7 second slot", 1, 1, 1, 3);
        send(48'h400); expect_ref("R2 lowest index", 1, 0, 0, 4);
        send(48'h500); expect_ref("R2 last updated", 1, 0, 0, 5);
    endtask

    function automatic logic [ADDR_W-1:0] sref(input int s, input int n);
        return (48'h1 << (20 + s)) + ADDR_W'(n * 4 * (s + 1));
    endfunction

    task automatic t_lru();
        do_reset();
        for (int s = 0; s < TBL; s++) begin
            send(sref(s, 0)); send(sref(s, 1)); send(sref(s, 2));
            expect_ref("R7 fill", 1, 1, s, 3);
        end
        send(sref(0, 3)); expect_ref("R7 touch 0", 1, 0, 0, 4);
        send(sref(8, 0)); send(sref(8, 1)); send(sref(8, 2));
        expect_ref("R7 evict lru", 1, 1, 1, 3);
        send(sref(2, 3)); expect_ref("R7 survivor", 1, 0, 2, 4);
        send(sref(1, 3)); expect_ref("R7 evicted redetect", 1, 1, 3, 3);
    endtask

    task automatic t_sat();
        do_reset();
        for (int n = 1; n <= 20; n++) begin
            send(48'h2000 + ADDR_W'(8 * n));
            if (n == 15 || n == 20) expect_ref("R9 saturate", 1, 0, 0, 15);
        end
        expect_cnt("R8 R9 long", 20, 20, 17);
    endtask

    initial begin
        t_reset();
        t_ascend();
        t_descend();
        t_zero();
        t_idle();
        t_window(30, 1'b1);
        t_window(31, 1'b0);
        t_priority();
        t_lru();
        t_sat();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule